// File: doc/BRIEF.md
# Delayed-Write Synchronous Static Memory

This block is a synchronous static memory whose write data trails its command by one clock. On each rising edge it samples a chip select, a write flag, per-lane write enables and an address. A read returns its word in the same cycle: the data is registered on the falling edge that follows the sampling edge. A write only names its target on the sampling edge. Its data word is taken on the next rising edge, so the block keeps the write in a one-entry pending buffer. The buffer holds the address, the lane mask and the data, and it is written into the array when the next write is sampled.

A read that hits the pending address returns the buffered lanes laid over the array contents, so software sees every write at once. The output enable is combinational and gates the data outputs without any clock. Word width and depth are parameters. The word is split into 9-bit lanes, each with its own write enable. Both the wide organization (36-bit words, 4 lanes) and the narrow one (18-bit words, 2 lanes) are covered by the parameters.

Top module: `lw_sram`

## Requirements
- R1: `sel`, `wr`, `lane_en` and `addr` are sampled on the rising edge of `clk`. A cycle with `sel`=0 is a no-op: it launches no read (q_en stays 0 after that cycle's falling edge) and queues no write (the addressed word keeps its contents).
- R2: For a write sampled on edge N, the data word on `din` is taken on rising edge N+1, even when `sel` is 0 on that edge.
- R3: A read sampled on rising edge N (`sel`=1, `wr`=0) presents the stored word on `q` after the falling edge of the same cycle. The word stays there until the next falling edge.
- R4: Lane i is bits [9i+8:9i] of the word. A write changes lane i only when `lane_en[i]`=1; the other lanes keep their old contents.
- R5: A read of the address held in the pending buffer returns the buffered lanes selected by the buffered mask, and array data in the remaining lanes.
- R6: Back-to-back writes each commit the previous pending write to the array, and both words read back correctly afterwards.
- R7: `q_en` = 1 only when `oe` = 1 and the cycle whose falling edge last passed launched a read. `oe` acts without a clock. `q` reads 0 whenever `q_en` is 0 (outputs floating).
- R8: In a write cycle, `q_en` is 0 after that cycle's falling edge.
- R9: Synchronous reset (`rst`=1, active high) clears the pending buffer and disables the outputs. A write still pending at reset is discarded, and its address keeps its earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands sampled on rising edge, read data registered on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select; 0 makes the cycle a no-op |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| lane_en | input | WORD_W/9 | Per-lane write enables, bit i covers bits [9i+8:9i] |
| addr | input | log2(DEPTH) | Word address |
| din | input | WORD_W | Write data, one cycle after its write command |
| oe | input | 1 | Asynchronous output enable |
| q | output | WORD_W | Read data, 0 when q_en is 0 |
| q_en | output | 1 | Output drivers active; when 0, q is high-impedance |

## Verification
The hardest case to reach from the ports is a read that lands on the pending buffer while the array still holds the older word, with only part of the lane mask set. The merge is only visible when both sources hold different values. The bench first fills every address with a known pattern. It then writes each address with every lane mask and reads that address immediately, before another write can flush the buffer. A further sequence puts a reset between a write's data cycle and any later write, which shows that the pending word is discarded.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lw_op_e;

  function automatic lw_op_e decode_op(input logic sel, input logic wr);
    if (!sel)    return OP_IDLE;
    else if (wr) return OP_WRITE;
    else         return OP_READ;
  endfunction
endpackage

// File: rtl/lw_pend_buf.sv
module lw_pend_buf #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [WORD_W-1:0] din,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_mask,
  output logic [WORD_W-1:0] pend_data,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [LANES-1:0]  commit_mask,
  output logic [WORD_W-1:0] commit_data
);
  logic have_data;
  logic owed;

  assign owed = pend_valid && !have_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      have_data  <= 1'b0;
      pend_addr  <= '0;
      pend_mask  <= '0;
      pend_data  <= '0;
    end else begin
      if (owed) begin
        pend_data <= din;
        have_data <= 1'b1;
      end
      if (wr_req) begin
        pend_addr  <= req_addr;
        pend_mask  <= req_mask;
        pend_valid <= 1'b1;
        have_data  <= 1'b0;
      end
    end
  end

  // A new write retires the held one; its data may be arriving this very edge.
  assign commit_en   = wr_req && pend_valid;
  assign commit_addr = pend_addr;
  assign commit_mask = pend_mask;
  assign commit_data = have_data ? pend_data : din;

  // R2: an owed data word is always taken on the following edge
  a_r2_data_taken: assert property (@(posedge clk) disable iff (rst)
    (owed && !wr_req) |=> have_data);

  // R9: reset empties the buffer
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !pend_valid);
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned LANES  = 4,
  parameter int unsigned DEPTH  = 512
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned LW = WORD_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g])
        mem[wr_addr] <= wr_data[g*LW +: LW];
    end

    always_ff @(negedge clk) begin
      lane_q <= mem[rd_addr];
    end

    assign rd_data[g*LW +: LW] = lane_q;
  end
endmodule

// File: rtl/lw_rd_out.sv
module lw_rd_out #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              pend_valid,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [LANES-1:0]  pend_mask,
  input  logic [WORD_W-1:0] pend_data,
  input  logic [WORD_W-1:0] arr_data,
  input  logic              oe,
  output logic              out_valid,
  output logic [WORD_W-1:0] q,
  output logic              q_en
);
  localparam int unsigned LW = WORD_W / LANES;

  logic [LANES-1:0]  fwd_sel;
  logic [WORD_W-1:0] fwd_data;
  logic [WORD_W-1:0] merged;

  always_ff @(negedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fwd_sel   <= '0;
      fwd_data  <= '0;
    end else begin
      out_valid <= rd_go;
      fwd_sel   <= (pend_valid && pend_addr == rd_addr) ? pend_mask : '0;
      fwd_data  <= pend_data;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LW +: LW] = fwd_sel[g] ? fwd_data[g*LW +: LW]
                                           : arr_data[g*LW +: LW];
  end

  assign q_en = oe && out_valid;
  assign q    = q_en ? merged : '0;
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned LANES  = WORD_W / lw_pkg::LANE_W,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [LANES-1:0]  lane_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic              oe,
  output logic [WORD_W-1:0] q,
  output logic              q_en
);
  import lw_pkg::*;

  lw_op_e op;
  logic   wr_req;
  logic   rd_go;
  logic [ADDR_W-1:0] rd_addr;

  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_mask;
  logic [WORD_W-1:0] pend_data;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_mask;
  logic [WORD_W-1:0] commit_data;
  logic [WORD_W-1:0] arr_data;
  logic              out_valid;

  assign op     = decode_op(sel, wr);
  assign wr_req = (op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_go   <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_go   <= (op == OP_READ);
      rd_addr <= addr;
    end
  end

  lw_pend_buf #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_pend (
    .clk, .rst,
    .wr_req, .req_addr(addr), .req_mask(lane_en), .din,
    .pend_valid, .pend_addr, .pend_mask, .pend_data,
    .commit_en, .commit_addr, .commit_mask, .commit_data
  );

  lw_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES), .DEPTH(DEPTH)) u_array (
    .clk,
    .wr_en(commit_en), .wr_addr(commit_addr), .wr_mask(commit_mask),
    .wr_data(commit_data), .rd_addr, .rd_data(arr_data)
  );

  lw_rd_out #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_out (
    .clk, .rst, .rd_go, .rd_addr,
    .pend_valid, .pend_addr, .pend_mask, .pend_data,
    .arr_data, .oe, .out_valid, .q, .q_en
  );

  // R8: a write cycle leaves the outputs off
  a_r8_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (sel && wr) |=> !out_valid);

  // R1: a deselected cycle launches no read
  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !out_valid);

  // R3: a sampled read is presented by the next rising edge
  a_r3_read_presented: assert property (@(posedge clk) disable iff (rst)
    (sel && !wr) |=> out_valid);
endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/100ps
module tb_lw_sram;
  localparam int W  = 18;
  localparam int D  = 16;
  localparam int L  = 2;
  localparam int AW = 4;

  logic clk = 0, rst = 1, sel = 0, wr = 0, oe = 1;
  logic [L-1:0]  lane_en = '0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  q;
  logic          q_en;

  logic [W-1:0] mdl [D];
  logic [W-1:0] next_din = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lw_sram #(.WORD_W(W), .DEPTH(D)) dut (
    .clk, .rst, .sel, .wr, .lane_en, .addr, .din, .oe, .q, .q_en
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int a, input int k);
    return W'((a * 7919 + k * 263 + 17) ^ (k << 9));
  endfunction

  // One bus cycle: drive, pass the rising edge, sample after the falling edge.
  task automatic step(input bit c, input bit w, input logic [L-1:0] b,
                      input int a, input logic [W-1:0] wd, input bit o,
                      input string tag);
    logic [W-1:0] eq;
    bit een;
    sel = c; wr = w; lane_en = b; addr = AW'(a); oe = o;
    din = next_din;
    next_din = wd;
    @(posedge clk); #4;
    een = o && c && !w;
    eq  = een ? mdl[a] : '0;
    chk({tag, " q_en"}, 32'(q_en), 32'(een));
    chk({tag, " q"}, 32'(q), 32'(eq));
    if (c && w)
      for (int l = 0; l < L; l++)
        if (b[l]) mdl[a][l*9 +: 9] = wd[l*9 +: 9];
  endtask

  initial begin
    logic [W-1:0] saved;
    // R9: reset state
    repeat (3) @(posedge clk);
    #4;
    chk("R9 reset q_en", 32'(q_en), 0);
    chk("R9 reset q", 32'(q), 0);
    rst = 0;

    // fill every word with full-lane writes (R4 full mask)
    for (int a = 0; a < D; a++) step(1, 1, '1, a, pat(a, 0), 1, "R4 fill");
    step(0, 0, '0, 0, '0, 1, "R1 idle");
    for (int a = 0; a < D; a++) step(1, 0, '0, a, '0, 1, "R3 read");

    // every lane mask, read right away (pending hit R5) and later (R4)
    for (int a = 0; a < D; a++)
      for (int m = 0; m < (1 << L); m++) begin
        step(1, 1, L'(m), a, pat(a, m + 1), 1, "R8 write");
        step(1, 0, '0, a, '0, 1, "R5 forward");
      end
    for (int a = 0; a < D; a++) step(1, 0, '0, a, '0, 1, "R4 mask");

    // back-to-back writes (R6)
    for (int a = 0; a < D; a += 2) begin
      step(1, 1, 2'b01, a, pat(a, 9), 1, "R6 w0");
      step(1, 1, 2'b10, a + 1, pat(a, 10), 1, "R6 w1");
      step(1, 1, '1, a, pat(a, 11), 1, "R6 w2");
      step(1, 0, '0, a + 1, '0, 1, "R6 rd1");
      step(1, 0, '0, a, '0, 1, "R6 rd0");
    end

    // deselected write queues nothing (R1)
    step(0, 1, '1, 5, pat(5, 50), 1, "R1 desel write");
    step(1, 0, '0, 5, '0, 1, "R1 unchanged");
    step(1, 1, '1, 6, pat(6, 51), 1, "R1 flush");
    step(1, 0, '0, 5, '0, 1, "R1 unchanged2");

    // data taken while deselected (R2)
    step(1, 1, '1, 7, pat(7, 60), 1, "R2 write");
    step(0, 0, '0, 0, '0, 1, "R2 data cycle");
    step(1, 0, '0, 7, '0, 1, "R2 fwd");
    step(1, 1, '1, 8, pat(8, 61), 1, "R2 flush");
    step(1, 0, '0, 7, '0, 1, "R2 array");

    // output enable, clocked and asynchronous (R7)
    step(1, 0, '0, 3, '0, 0, "R7 oe low");
    step(1, 0, '0, 3, '0, 1, "R7 oe high");
    oe = 0; #0.3;
    chk("R7 async off q_en", 32'(q_en), 0);
    chk("R7 async off q", 32'(q), 0);
    oe = 1; #0.3;
    chk("R7 async on q_en", 32'(q_en), 1);
    chk("R7 async on q", 32'(q), 32'(mdl[3]));

    // reset discards a pending write (R9)
    saved = mdl[3];
    step(1, 1, '1, 3, pat(3, 70), 1, "R9 write");
    step(0, 0, '0, 0, '0, 1, "R9 data");
    mdl[3] = saved;
    rst = 1;
    @(posedge clk); #4;
    chk("R9 mid reset q_en", 32'(q_en), 0);
    rst = 0;
    step(1, 0, '0, 3, '0, 1, "R9 old kept");
    step(1, 1, '1, 4, pat(4, 71), 1, "R9 next write");
    step(1, 0, '0, 3, '0, 1, "R9 old kept2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule